// File: doc/BRIEF.md
# Voice Row Sequencer

This block steps a record, playback or cue operation across the rows of a voice memory. A serial-port decoder hands it one command strobe with its fields: power, run, play or record, cue, keep-pointer and a row address. A sample-rate strobe paces the row timer. The block holds the current row pointer and keeps a power-up warm-up window during which run requests are refused. It drives a row clock that marks where each row ends. Overflow at the top of memory, and end-of-message markers reported by the storage array, stop the operation, raise a flag and raise an interrupt.

A normal row lasts `ROW_HI + ROW_LO` sample strobes, and the row clock is low only for the last `ROW_LO` of them. In cue mode the timer advances on every clock cycle, so a row lasts `CUE_HI + CUE_LO` cycles with the same high-then-low shape. The first row of a fresh recording is stretched: its high part is longer by `ROW_LO` strobes. A command with keep-pointer clear loads the address. While keep-pointer stays clear, every row end replays the same row.

Top module: `row_seq`

## Requirements
- R1: After reset the pointer is 0, busy, overflow, end-of-message, interrupt and rejected are all 0, the row clock is 1, and the block is powered down.
- R2: A command with cmd_pwr=1 received while powered down starts a warm-up of PUD_TICKS sample strobes. A command with cmd_run=1 received while powered down or still warming leaves busy at 0 and sets rejected to 1. Once the warm-up is over, a run command sets busy and clears rejected.
- R3: In play or record, each row lasts ROW_HI+ROW_LO sample strobes. The row clock is 1 for the first ROW_HI of them and 0 for the last ROW_LO.
- R4: In cue mode (cmd_play=1, cmd_cue=1), the row timer steps on every clock. The row clock is 1 for CUE_HI cycles and then 0 for CUE_LO cycles.
- R5: When a run command starts the row timer for a recording (cmd_play=0), the row clock stays 1 for ROW_HI+ROW_LO strobes on that first row.
- R6: A run command with cmd_keep=0 loads cmd_addr into the pointer. While the keep bit stays 0, each row end leaves the pointer on the same row.
- R7: With cmd_keep=1, each row end advances the pointer by exactly one. With no command, the pointer never changes in any other way.
- R8: A row end on row ROWS-1 with cmd_keep=1 sets overflow and interrupt and clears busy.
- R9: During playback, eom_mark=1 on a step sets end-of-message and interrupt, clears busy and leaves the pointer unchanged.
- R10: During cue, eom_mark=1 on a step sets end-of-message and interrupt, clears busy and moves the pointer to the next row. On the last row it sets overflow instead of advancing.
- R11: During recording, eom_mark has no effect: end-of-message stays 0 and recording continues.
- R12: Any command clears overflow, end-of-message and interrupt on the next cycle. A run=0 command from a powered block stops the operation.
- R13: A command with cmd_pwr=0 stops any operation and powers the block down, so that later run commands are rejected until a new warm-up has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_pwr | input | 1 | 1 keeps or brings power up, 0 powers down |
| cmd_run | input | 1 | 1 starts or continues an operation, 0 stops it |
| cmd_play | input | 1 | 1 play or cue, 0 record |
| cmd_cue | input | 1 | Selects cue when cmd_play is 1 |
| cmd_keep | input | 1 | 1 keeps the current pointer, 0 loads cmd_addr |
| cmd_addr | input | AW | Row address to load |
| smp_tick | input | 1 | Sample-rate strobe |
| eom_mark | input | 1 | End-of-message marker at the current position |
| row_ptr | output | AW | Current row pointer |
| ovf_flag | output | 1 | Overflow flag |
| eom_flag | output | 1 | End-of-message flag |
| irq | output | 1 | Interrupt request |
| row_clk | output | 1 | Row clock, low at the end of each row |
| busy | output | 1 | An operation is running |
| rejected | output | 1 | The last run command was refused |

## Verification
The assertions assume that cmd_valid is a single-cycle strobe, that cmd_addr is always below ROWS, and that smp_tick pulses are separated by idle cycles. They also assume that reset is held over at least one clock edge. The stimulus meets all of these: commands are sent one cycle at a time, and only rows 0 to 5 are addressed in a six-row build. The sample strobe comes every fourth cycle from a fixed phase counter, and reset is held for three cycles. The end-of-message marker is derived from the pointer the block reports. This places it on one chosen row, which tests stopping in play and cue and being ignored in record.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
  typedef enum logic [1:0] {
    OP_REC  = 2'd0,
    OP_PLAY = 2'd1,
    OP_CUE  = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    PW_OFF  = 2'd0,
    PW_WARM = 2'd1,
    PW_ON   = 2'd2
  } pw_e;
endpackage

// File: rtl/rowseq_pwr.sv
module rowseq_pwr
  import rowseq_pkg::*;
#(
  parameter int PUD_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic up_req,
  input  logic down_req,
  output logic ready
);
  localparam int PW = $clog2(PUD_TICKS + 1);

  pw_e           st_q;
  logic [PW-1:0] cnt_q;

  // Warm-up sequencer: OFF -> WARM (PUD_TICKS strobes) -> ON
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PW_OFF;
      cnt_q <= '0;
    end else if (down_req) begin
      st_q  <= PW_OFF;
      cnt_q <= '0;
    end else begin
      case (st_q)
        PW_OFF: begin
          if (up_req) begin
            st_q  <= PW_WARM;
            cnt_q <= '0;
          end
        end
        PW_WARM: begin
          if (tick) begin
            if (cnt_q == PW'(PUD_TICKS - 1)) st_q <= PW_ON;
            else                             cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign ready = (st_q == PW_ON);
endmodule

// File: rtl/rowseq_timer.sv
module rowseq_timer #(
  parameter int ROW_HI = 1400,
  parameter int ROW_LO = 200,
  parameter int CUE_HI = 7,
  parameter int CUE_LO = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic hold,
  input  logic start,
  input  logic start_stretch,
  input  logic cue_cur,
  input  logic run_cur,
  input  logic cue_nxt,
  input  logic run_nxt,
  output logic row_end,
  output logic row_clk
);
  localparam int CW = $clog2(ROW_HI + 2 * ROW_LO + 1);

  logic [CW-1:0] cnt_q, cnt_n, last_cnt;
  logic          str_q, str_n;

  function automatic logic [CW-1:0] hi_of(input logic cue, input logic str);
    logic [CW-1:0] base;
    base = cue ? CW'(CUE_HI) : CW'(ROW_HI);
    return base + (str ? CW'(ROW_LO) : CW'(0));
  endfunction

  function automatic logic [CW-1:0] lo_of(input logic cue);
    return cue ? CW'(CUE_LO) : CW'(ROW_LO);
  endfunction

  assign last_cnt = hi_of(cue_cur, str_q) + lo_of(cue_cur) - 1'b1;
  assign row_end  = run_cur & step & ~hold & (cnt_q == last_cnt);

  always_comb begin
    cnt_n = cnt_q;
    str_n = str_q;
    if (start) begin
      cnt_n = '0;
      str_n = start_stretch;
    end else if (!hold && run_cur && step) begin
      if (cnt_q == last_cnt) begin
        cnt_n = '0;
        str_n = 1'b0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  // Row clock registered from next-state values so the pin never glitches
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      str_q   <= 1'b0;
      row_clk <= 1'b1;
    end else begin
      cnt_q   <= cnt_n;
      str_q   <= str_n;
      row_clk <= !(run_nxt && (cnt_n >= hi_of(cue_nxt, str_n)));
    end
  end
endmodule

// File: rtl/rowseq_ptr.sv
module rowseq_ptr #(
  parameter int ROWS = 1200,
  localparam int AW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic          at_last
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (adv)  ptr <= ptr + 1'b1;
  end

  assign at_last = (ptr == AW'(ROWS - 1));
endmodule

// File: rtl/row_seq.sv
module row_seq
  import rowseq_pkg::*;
#(
  parameter int ROWS      = 1200,
  parameter int ROW_HI    = 1400,
  parameter int ROW_LO    = 200,
  parameter int CUE_HI    = 7,
  parameter int CUE_LO    = 1,
  parameter int PUD_TICKS = 200,
  localparam int AW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_pwr,
  input  logic          cmd_run,
  input  logic          cmd_play,
  input  logic          cmd_cue,
  input  logic          cmd_keep,
  input  logic [AW-1:0] cmd_addr,
  input  logic          smp_tick,
  input  logic          eom_mark,
  output logic [AW-1:0] row_ptr,
  output logic          ovf_flag,
  output logic          eom_flag,
  output logic          irq,
  output logic          row_clk,
  output logic          busy,
  output logic          rejected
);
  op_e  mode_q, mode_n, req_mode;
  logic keep_q, keep_n;
  logic busy_n, ovf_n, eom_n, irq_n, rej_n;
  logic pw_ready, step, row_end, at_last;
  logic t_start, ld, adv;

  assign req_mode = cmd_play ? (cmd_cue ? OP_CUE : OP_PLAY) : OP_REC;
  assign step     = (mode_q == OP_CUE) | smp_tick;

  rowseq_pwr #(.PUD_TICKS(PUD_TICKS)) pwr_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (smp_tick),
    .up_req   (cmd_valid & cmd_pwr),
    .down_req (cmd_valid & ~cmd_pwr),
    .ready    (pw_ready)
  );

  rowseq_timer #(
    .ROW_HI(ROW_HI), .ROW_LO(ROW_LO), .CUE_HI(CUE_HI), .CUE_LO(CUE_LO)
  ) tmr_i (
    .clk           (clk),
    .rst           (rst),
    .step          (step),
    .hold          (cmd_valid),
    .start         (t_start),
    .start_stretch (mode_n == OP_REC),
    .cue_cur       (mode_q == OP_CUE),
    .run_cur       (busy),
    .cue_nxt       (mode_n == OP_CUE),
    .run_nxt       (busy_n),
    .row_end       (row_end),
    .row_clk       (row_clk)
  );

  rowseq_ptr #(.ROWS(ROWS)) ptr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (cmd_addr),
    .adv      (adv),
    .ptr      (row_ptr),
    .at_last  (at_last)
  );

  // Command handling has priority; row events are processed only between commands
  always_comb begin
    busy_n  = busy;
    mode_n  = mode_q;
    keep_n  = keep_q;
    ovf_n   = ovf_flag;
    eom_n   = eom_flag;
    irq_n   = irq;
    rej_n   = rejected;
    t_start = 1'b0;
    ld      = 1'b0;
    adv     = 1'b0;
    if (cmd_valid) begin
      ovf_n = 1'b0;
      eom_n = 1'b0;
      irq_n = 1'b0;
      if (!cmd_pwr) begin
        busy_n = 1'b0;
        rej_n  = 1'b0;
      end else if (!pw_ready) begin
        rej_n = cmd_run;
      end else begin
        rej_n = 1'b0;
        if (cmd_run) begin
          mode_n  = req_mode;
          keep_n  = cmd_keep;
          busy_n  = 1'b1;
          ld      = !cmd_keep;
          t_start = !cmd_keep || !busy || (req_mode != mode_q);
        end else begin
          busy_n = 1'b0;
        end
      end
    end else if (busy) begin
      if (eom_mark && step && (mode_q != OP_REC)) begin
        eom_n  = 1'b1;
        irq_n  = 1'b1;
        busy_n = 1'b0;
        if (mode_q == OP_CUE) begin
          if (at_last) ovf_n = 1'b1;
          else         adv   = 1'b1;
        end
      end else if (row_end && keep_q) begin
        if (at_last) begin
          ovf_n  = 1'b1;
          irq_n  = 1'b1;
          busy_n = 1'b0;
        end else begin
          adv = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      mode_q   <= OP_PLAY;
      keep_q   <= 1'b0;
      ovf_flag <= 1'b0;
      eom_flag <= 1'b0;
      irq      <= 1'b0;
      rejected <= 1'b0;
    end else begin
      busy     <= busy_n;
      mode_q   <= mode_n;
      keep_q   <= keep_n;
      ovf_flag <= ovf_n;
      eom_flag <= eom_n;
      irq      <= irq_n;
      rejected <= rej_n;
    end
  end
endmodule

// File: rtl/row_seq_chk.sv
module row_seq_chk
  import rowseq_pkg::*;
#(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          busy,
  input logic          row_clk,
  input logic          irq,
  input logic          ovf_flag,
  input logic          eom_flag,
  input logic          ready,
  input logic [AW-1:0] row_ptr,
  input op_e           mode
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!busy && row_clk && !irq && !ovf_flag && !eom_flag && row_ptr == '0));

  a_r2_start_needs_power: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ready));

  a_r3_low_only_busy: assert property (@(posedge clk) disable iff (rst)
    !row_clk |-> busy);

  a_r7_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (!$past(cmd_valid) && row_ptr != $past(row_ptr)) |-> (row_ptr == $past(row_ptr) + 1'b1));

  a_r8_ovf_stops: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> (!busy && irq));

  a_r9_eom_stops: assert property (@(posedge clk) disable iff (rst)
    $rose(eom_flag) |-> (!busy && irq));

  a_r11_no_eom_record: assert property (@(posedge clk) disable iff (rst)
    $rose(eom_flag) |-> ($past(mode) != OP_REC));

  a_r12_cmd_clears_irq: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !irq);
endmodule

bind row_seq row_seq_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .row_clk   (row_clk),
  .irq       (irq),
  .ovf_flag  (ovf_flag),
  .eom_flag  (eom_flag),
  .ready     (pw_ready),
  .row_ptr   (row_ptr),
  .mode      (mode_q)
);

// File: tb/row_seq_tb_top.sv
`timescale 1ns/1ps
module row_seq_tb_top;
  localparam int ROWS = 6, RH = 6, RL = 2, CH = 3, CL = 1, PUD = 4;
  localparam int AW = $clog2(ROWS);

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 0, cmd_pwr = 0, cmd_run = 0, cmd_play = 0, cmd_cue = 0, cmd_keep = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic smp_tick = 0, eom_mark = 0;
  logic [AW-1:0] row_ptr;
  logic ovf_flag, eom_flag, irq, row_clk, busy, rejected;

  int checks = 0, fails = 0, phase = 0, eom_row = 0;
  bit eom_en = 0, last_tick = 0, done = 0, live = 0;

  // reference model state
  int m_pw, m_wc, m_mode, m_ptr, m_cnt;
  bit m_busy, m_keep, m_str, m_ovf, m_eom, m_irq, m_rej, m_rc;

  always #10 clk = ~clk;

  row_seq #(.ROWS(ROWS), .ROW_HI(RH), .ROW_LO(RL), .CUE_HI(CH), .CUE_LO(CL), .PUD_TICKS(PUD)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_pwr(cmd_pwr), .cmd_run(cmd_run),
    .cmd_play(cmd_play), .cmd_cue(cmd_cue), .cmd_keep(cmd_keep), .cmd_addr(cmd_addr),
    .smp_tick(smp_tick), .eom_mark(eom_mark), .row_ptr(row_ptr), .ovf_flag(ovf_flag),
    .eom_flag(eom_flag), .irq(irq), .row_clk(row_clk), .busy(busy), .rejected(rejected)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model, updated at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_pw = 0; m_wc = 0; m_busy = 0; m_mode = 1; m_keep = 0; m_ptr = 0; m_cnt = 0;
      m_str = 0; m_ovf = 0; m_eom = 0; m_irq = 0; m_rej = 0; m_rc = 1;
    end else begin
      int hi, len, nm;
      bit rdy, step;
      rdy  = (m_pw == 2);
      step = (m_mode == 2) || smp_tick;
      hi   = ((m_mode == 2) ? CH : RH) + (m_str ? RL : 0);
      len  = hi + ((m_mode == 2) ? CL : RL);
      if (cmd_valid && !cmd_pwr) begin m_pw = 0; m_wc = 0; end
      else if (m_pw == 0) begin if (cmd_valid) begin m_pw = 1; m_wc = 0; end end
      else if (m_pw == 1 && smp_tick) begin if (m_wc == PUD - 1) m_pw = 2; else m_wc++; end
      if (cmd_valid) begin
        m_ovf = 0; m_eom = 0; m_irq = 0;
        if (!cmd_pwr) begin m_busy = 0; m_rej = 0; end
        else if (!rdy) m_rej = cmd_run;
        else begin
          m_rej = 0;
          if (cmd_run) begin
            nm = cmd_play ? (cmd_cue ? 2 : 1) : 0;
            if (!cmd_keep || !m_busy || nm != m_mode) begin m_cnt = 0; m_str = (nm == 0); end
            if (!cmd_keep) m_ptr = int'(cmd_addr);
            m_mode = nm; m_keep = cmd_keep; m_busy = 1;
          end else m_busy = 0;
        end
      end else if (m_busy) begin
        if (eom_mark && step && m_mode != 0) begin
          m_eom = 1; m_irq = 1; m_busy = 0;
          if (m_mode == 2) begin if (m_ptr == ROWS - 1) m_ovf = 1; else m_ptr++; end
          m_cnt = (m_cnt == len - 1) ? 0 : m_cnt + 1;
        end else if (step && m_cnt == len - 1) begin
          m_cnt = 0; m_str = 0;
          if (m_keep) begin
            if (m_ptr == ROWS - 1) begin m_ovf = 1; m_irq = 1; m_busy = 0; end
            else m_ptr++;
          end
        end else if (step) m_cnt++;
      end
      hi   = ((m_mode == 2) ? CH : RH) + (m_str ? RL : 0);
      m_rc = !(m_busy && m_cnt >= hi);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk(int'(row_ptr) == m_ptr, "R7 model pointer", int'(row_ptr), m_ptr);
      chk(row_clk == m_rc, "R3 model row clock", int'(row_clk), int'(m_rc));
      chk(busy == m_busy, "R12 model busy", int'(busy), int'(m_busy));
      chk(ovf_flag == m_ovf, "R8 model overflow", int'(ovf_flag), int'(m_ovf));
      chk(eom_flag == m_eom, "R9 model eom", int'(eom_flag), int'(m_eom));
      chk(irq == m_irq, "R12 model irq", int'(irq), int'(m_irq));
      chk(rejected == m_rej, "R2 model rejected", int'(rejected), int'(m_rej));
    end
  end

  task automatic cyc();
    smp_tick  = (phase == 3);
    phase     = (phase + 1) % 4;
    eom_mark  = eom_en && (row_ptr == AW'(eom_row));
    last_tick = smp_tick;
    @(negedge clk);
  endtask

  task automatic send(input bit p, input bit r, input bit pl, input bit c, input bit k, input int a);
    cmd_pwr = p; cmd_run = r; cmd_play = pl; cmd_cue = c; cmd_keep = k; cmd_addr = AW'(a);
    cmd_valid = 1;
    cyc();
    cmd_valid = 0;
  endtask

  task automatic wait_clk(input bit lvl);
    for (int g = 0; g < 1000 && row_clk != lvl; g++) cyc();
  endtask

  task automatic count_clk(input bit lvl, input bit per_cycle, output int n);
    n = 0;
    for (int g = 0; g < 1000 && row_clk == lvl; g++) begin
      cyc();
      n += per_cycle ? 1 : int'(last_tick);
    end
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 2000 && busy; g++) cyc();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=expired expected=completed");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0; live = 1;
    cyc();
    chk(row_ptr == '0, "R1 reset pointer", int'(row_ptr), 0);
    chk(busy == 0, "R1 reset busy", int'(busy), 0);
    chk(row_clk == 1, "R1 reset row clock", int'(row_clk), 1);
    chk(irq == 0, "R1 reset irq", int'(irq), 0);
    chk(rejected == 0, "R1 reset rejected", int'(rejected), 0);

    send(1, 1, 1, 0, 0, 2);
    chk(rejected == 1, "R2 run while off rejected", int'(rejected), 1);
    chk(busy == 0, "R2 run while off idle", int'(busy), 0);
    send(1, 1, 1, 0, 0, 2);
    chk(rejected == 1, "R2 run while warming rejected", int'(rejected), 1);
    repeat (24) cyc();
    send(1, 1, 1, 0, 0, 2);
    chk(busy == 1, "R2 run after warm-up", int'(busy), 1);
    chk(rejected == 0, "R2 rejected cleared", int'(rejected), 0);
    chk(int'(row_ptr) == 2, "R6 address loaded", int'(row_ptr), 2);

    wait_clk(0);
    count_clk(0, 0, n); chk(n == RL, "R3 low strobes", n, RL);
    count_clk(1, 0, n); chk(n == RH, "R3 high strobes", n, RH);
    chk(int'(row_ptr) == 2, "R6 row repeats", int'(row_ptr), 2);

    send(1, 1, 1, 0, 1, 0);
    for (int g = 0; g < 1000 && row_ptr == AW'(2); g++) cyc();
    chk(int'(row_ptr) == 3, "R7 pointer advances", int'(row_ptr), 3);
    wait_idle();
    chk(ovf_flag == 1, "R8 overflow set", int'(ovf_flag), 1);
    chk(irq == 1, "R8 irq set", int'(irq), 1);
    chk(int'(row_ptr) == ROWS - 1, "R8 pointer at last row", int'(row_ptr), ROWS - 1);

    send(1, 0, 1, 0, 1, 0);
    chk(ovf_flag == 0, "R12 overflow cleared", int'(ovf_flag), 0);
    chk(irq == 0, "R12 irq cleared", int'(irq), 0);

    eom_row = 2; eom_en = 1;
    send(1, 1, 1, 0, 0, 1);
    send(1, 1, 1, 0, 1, 0);
    wait_idle();
    chk(eom_flag == 1, "R9 play eom set", int'(eom_flag), 1);
    chk(irq == 1, "R9 play irq", int'(irq), 1);
    chk(int'(row_ptr) == 2, "R9 pointer kept", int'(row_ptr), 2);

    eom_row = 3;
    send(1, 1, 1, 1, 0, 0);
    wait_clk(0);
    count_clk(0, 1, n); chk(n == CL, "R4 cue low cycles", n, CL);
    count_clk(1, 1, n); chk(n == CH, "R4 cue high cycles", n, CH);
    send(1, 1, 1, 1, 1, 0);
    wait_idle();
    chk(eom_flag == 1, "R10 cue eom set", int'(eom_flag), 1);
    chk(int'(row_ptr) == 4, "R10 pointer on next row", int'(row_ptr), 4);
    chk(ovf_flag == 0, "R10 no overflow", int'(ovf_flag), 0);

    eom_row = 1;
    send(1, 1, 0, 0, 0, 1);
    count_clk(1, 0, n); chk(n == RH + RL, "R5 stretched first row", n, RH + RL);
    chk(eom_flag == 0, "R11 marker ignored in record", int'(eom_flag), 0);
    chk(busy == 1, "R11 record continues", int'(busy), 1);
    send(1, 1, 0, 0, 1, 0);
    wait_idle();
    chk(ovf_flag == 1, "R8 record overflow", int'(ovf_flag), 1);
    chk(eom_flag == 0, "R11 no eom after record", int'(eom_flag), 0);
    eom_en = 0;

    send(1, 1, 1, 0, 0, 0);
    send(0, 0, 0, 0, 0, 0);
    chk(busy == 0, "R13 power-down stops", int'(busy), 0);
    send(1, 1, 1, 0, 0, 2);
    chk(rejected == 1, "R13 rejected after power-down", int'(rejected), 1);
    repeat (24) cyc();
    send(1, 1, 1, 0, 0, 2);
    chk(busy == 1, "R13 accepted after new warm-up", int'(busy), 1);
    repeat (4) cyc();

    done = 1;
    summary();
    $finish;
  end
endmodule